// File: doc/BRIEF.md
# Multi-Cycle Processor Sequencing Controller

This block is the control unit of a processor that runs each instruction over several clock cycles and re-uses one ALU and one memory port across them. A state register walks every instruction through fetch and decode. It then takes a path chosen by the opcode: address arithmetic and a memory read or write, an ALU operation and a register write, a conditional branch, or a jump. The number of cycles depends on the instruction class. In every state a Moore decoder drives the full set of datapath strobes and multiplexer selects, and any strobe that the state does not name is held low.

Two trap states sit beside the normal paths. An opcode that decode does not recognise leads to the illegal-instruction trap. An overflow reported by the ALU during a register-register operation leads to the overflow trap, and that path skips the result write. Each trap saves the return address, records a one-bit cause code and loads the program counter from the handler-vector input of the PC multiplexer. The next cycle is a fresh fetch. The block drives a separate datapath that holds the instruction register, register file, ALU and memory.

Top module: `mcCtrlFsm`

## Requirements
- R1: While `rstN` is low, and in the first cycle after it is released, the controller is in the fetch state and shows the fetch strobe pattern. An asynchronous reset taken in the middle of an instruction forces the fetch pattern at once.
- R2: Fetch drives memRd=1, instrLatch=1, addrFromAlu=0, aluASel=0, aluBSel=01, aluMode=00, pcSel=00 and pcLoad=1. The next state is always decode.
- R3: Decode drives aluASel=0, aluBSel=11 and aluMode=00. It then dispatches on `opcode`: 100011 (load) and 101011 (store) go to address computation, 000000 (register-register) goes to ALU execute, 000100 (branch-if-equal) goes to branch and 000010 (jump) goes to jump.
- R4: Address computation drives aluASel=1, aluBSel=10 and aluMode=00. It continues to memory read for a load and to memory write for a store.
- R5: A load runs 5 cycles: fetch, decode, address, a read cycle with memRd=1 and addrFromAlu=1, then a write-back cycle with rfWrite=1, wbFromMem=1 and rfDstSel=0.
- R6: A store runs 4 cycles. Its last cycle drives memWr=1 and addrFromAlu=1.
- R7: A register-register instruction runs 4 cycles. The execute cycle drives aluASel=1, aluBSel=00 and aluMode=10. The completion cycle drives rfWrite=1, rfDstSel=1 and wbFromMem=0.
- R8: A branch runs 3 cycles. Its last cycle drives aluASel=1, aluBSel=00, aluMode=01, pcLoadIfEq=1 and pcSel=01, with pcLoad=0.
- R9: A jump runs 3 cycles. Its last cycle drives pcLoad=1 and pcSel=10.
- R10: Any other opcode in decode leads to the illegal trap. Each trap cycle drives causeLoad=1, retAddrLoad=1, pcLoad=1, aluASel=0, aluBSel=01, aluMode=01 and pcSel=11, and the next state is fetch. In the illegal trap causeCode=0.
- R11: `aluOvf` high during ALU execute leads to the overflow trap (causeCode=1) in place of completion, so no register write occurs. `aluOvf` has no effect in any other state.
- R12: Every strobe not listed for a state is 0 in that state. memRd and memWr are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| opcode | input | 6 | Opcode field from the instruction register |
| aluOvf | input | 1 | ALU signed-overflow flag |
| addrFromAlu | output | 1 | Memory address from the ALU result register (1) or from the PC (0) |
| memRd | output | 1 | Memory read |
| memWr | output | 1 | Memory write |
| instrLatch | output | 1 | Load the instruction register |
| wbFromMem | output | 1 | Register write data from the memory data register (1) or from the ALU result (0) |
| pcLoad | output | 1 | Unconditional PC write |
| pcLoadIfEq | output | 1 | PC write when the ALU zero flag is set |
| pcSel | output | 2 | PC source: 00 ALU, 01 ALU result register, 10 jump target, 11 handler vector |
| aluMode | output | 2 | ALU mode: 00 add, 01 subtract, 10 function field |
| aluASel | output | 1 | ALU A operand: 0 PC, 1 register A |
| aluBSel | output | 2 | ALU B operand: 00 register B, 01 constant 4, 10 immediate, 11 shifted immediate |
| rfWrite | output | 1 | Register file write |
| rfDstSel | output | 1 | Destination field: 1 rd, 0 rt |
| causeLoad | output | 1 | Write the cause register |
| causeCode | output | 1 | Cause value: 0 illegal opcode, 1 overflow |
| retAddrLoad | output | 1 | Write the return-address register |

## Verification
A vector table runs each of the five instruction classes and checks the full strobe word in every cycle. Each run must also return to fetch after exactly the cycle count of its class, which shows that the dispatch and the path lengths are both right. The same register-register opcode is run with the overflow flag low and then high, so completion and the overflow trap are told apart. Loads, stores and jumps are also run with the flag high, which shows the flag is ignored outside execute. Two undefined opcodes, one of them differing from the jump code by a single bit, check the illegal trap. A reset asserted mid-decode checks the asynchronous return to fetch.

// File: rtl/mcCtrlPkg.sv
package mcCtrlPkg;
  localparam int OPC_W = 6;
  localparam int ST_W  = 4;

  localparam logic [OPC_W-1:0] OPC_REG   = 6'b000000;
  localparam logic [OPC_W-1:0] OPC_LOAD  = 6'b100011;
  localparam logic [OPC_W-1:0] OPC_STORE = 6'b101011;
  localparam logic [OPC_W-1:0] OPC_BEQ   = 6'b000100;
  localparam logic [OPC_W-1:0] OPC_JUMP  = 6'b000010;

  typedef enum logic [ST_W-1:0] {
    stFetch    = 4'd0,
    stDecode   = 4'd1,
    stAddr     = 4'd2,
    stMemRead  = 4'd3,
    stLoadWb   = 4'd4,
    stMemWrite = 4'd5,
    stExecR    = 4'd6,
    stRDone    = 4'd7,
    stBranch   = 4'd8,
    stJump     = 4'd9,
    stTrapIll  = 4'd10,
    stTrapOvf  = 4'd11
  } mcState_t;

  typedef struct packed {
    logic       addrFromAlu;
    logic       memRd;
    logic       memWr;
    logic       instrLatch;
    logic       wbFromMem;
    logic       pcLoad;
    logic       pcLoadIfEq;
    logic [1:0] pcSel;
    logic [1:0] aluMode;
    logic       aluASel;
    logic [1:0] aluBSel;
    logic       rfWrite;
    logic       rfDstSel;
    logic       causeLoad;
    logic       causeCode;
    logic       retAddrLoad;
  } mcStrobes_t;
endpackage

// File: rtl/mcSeqCore.sv
module mcSeqCore
  import mcCtrlPkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [OPC_W-1:0] opcode,
  input  logic             aluOvf,
  output mcState_t         curState
);
  mcState_t nextState;

  always_comb begin
    nextState = stFetch;
    unique case (curState)
      stFetch:    nextState = stDecode;
      stDecode: begin
        if (opcode == OPC_LOAD || opcode == OPC_STORE) nextState = stAddr;
        else if (opcode == OPC_REG)                    nextState = stExecR;
        else if (opcode == OPC_BEQ)                    nextState = stBranch;
        else if (opcode == OPC_JUMP)                   nextState = stJump;
        else                                           nextState = stTrapIll;
      end
      stAddr:     nextState = (opcode == OPC_LOAD) ? stMemRead : stMemWrite;
      stMemRead:  nextState = stLoadWb;
      stExecR:    nextState = aluOvf ? stTrapOvf : stRDone;
      default:    nextState = stFetch;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) curState <= stFetch;
    else       curState <= nextState;
  end

  // R2: fetch is always followed by decode
  assert_fetch_to_decode_R2: assert property (@(posedge clk) disable iff (!rstN)
    curState == stFetch |=> curState == stDecode);
  // R11: overflow during execute diverts to the overflow trap
  assert_ovf_trap_R11: assert property (@(posedge clk) disable iff (!rstN)
    (curState == stExecR && aluOvf) |=> curState == stTrapOvf);
  // R10: both traps return to fetch
  assert_trap_return_R10: assert property (@(posedge clk) disable iff (!rstN)
    (curState == stTrapIll || curState == stTrapOvf) |=> curState == stFetch);
endmodule

// File: rtl/mcStrobeDecode.sv
module mcStrobeDecode
  import mcCtrlPkg::*;
(
  input  mcState_t   curState,
  output mcStrobes_t strobes
);
  always_comb begin
    strobes = '0;
    unique case (curState)
      stFetch: begin
        strobes.memRd      = 1'b1;
        strobes.instrLatch = 1'b1;
        strobes.aluBSel    = 2'b01;
        strobes.pcLoad     = 1'b1;
      end
      stDecode:  strobes.aluBSel = 2'b11;
      stAddr: begin
        strobes.aluASel = 1'b1;
        strobes.aluBSel = 2'b10;
      end
      stMemRead: begin
        strobes.memRd       = 1'b1;
        strobes.addrFromAlu = 1'b1;
      end
      stLoadWb: begin
        strobes.rfWrite   = 1'b1;
        strobes.wbFromMem = 1'b1;
      end
      stMemWrite: begin
        strobes.memWr       = 1'b1;
        strobes.addrFromAlu = 1'b1;
      end
      stExecR: begin
        strobes.aluASel = 1'b1;
        strobes.aluMode = 2'b10;
      end
      stRDone: begin
        strobes.rfWrite  = 1'b1;
        strobes.rfDstSel = 1'b1;
      end
      stBranch: begin
        strobes.aluASel    = 1'b1;
        strobes.aluMode    = 2'b01;
        strobes.pcLoadIfEq = 1'b1;
        strobes.pcSel      = 2'b01;
      end
      stJump: begin
        strobes.pcLoad = 1'b1;
        strobes.pcSel  = 2'b10;
      end
      stTrapIll, stTrapOvf: begin
        strobes.causeLoad   = 1'b1;
        strobes.retAddrLoad = 1'b1;
        strobes.pcLoad      = 1'b1;
        strobes.aluBSel     = 2'b01;
        strobes.aluMode     = 2'b01;
        strobes.pcSel       = 2'b11;
        strobes.causeCode   = (curState == stTrapOvf);
      end
      default: strobes = '0;
    endcase
  end
endmodule

// File: rtl/mcCtrlFsm.sv
module mcCtrlFsm
  import mcCtrlPkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [OPC_W-1:0] opcode,
  input  logic             aluOvf,
  output logic             addrFromAlu,
  output logic             memRd,
  output logic             memWr,
  output logic             instrLatch,
  output logic             wbFromMem,
  output logic             pcLoad,
  output logic             pcLoadIfEq,
  output logic [1:0]       pcSel,
  output logic [1:0]       aluMode,
  output logic             aluASel,
  output logic [1:0]       aluBSel,
  output logic             rfWrite,
  output logic             rfDstSel,
  output logic             causeLoad,
  output logic             causeCode,
  output logic             retAddrLoad
);
  mcState_t   curState;
  mcStrobes_t strobes;

  mcSeqCore uSeq (
    .clk(clk), .rstN(rstN), .opcode(opcode), .aluOvf(aluOvf), .curState(curState)
  );

  mcStrobeDecode uDec (.curState(curState), .strobes(strobes));

  assign addrFromAlu = strobes.addrFromAlu;
  assign memRd       = strobes.memRd;
  assign memWr       = strobes.memWr;
  assign instrLatch  = strobes.instrLatch;
  assign wbFromMem   = strobes.wbFromMem;
  assign pcLoad      = strobes.pcLoad;
  assign pcLoadIfEq  = strobes.pcLoadIfEq;
  assign pcSel       = strobes.pcSel;
  assign aluMode     = strobes.aluMode;
  assign aluASel     = strobes.aluASel;
  assign aluBSel     = strobes.aluBSel;
  assign rfWrite     = strobes.rfWrite;
  assign rfDstSel    = strobes.rfDstSel;
  assign causeLoad   = strobes.causeLoad;
  assign causeCode   = strobes.causeCode;
  assign retAddrLoad = strobes.retAddrLoad;

  // R12: one memory access direction at a time
  assert_mem_excl_R12: assert property (@(posedge clk) disable iff (!rstN)
    !(memRd && memWr));
  // R10: a cause write always comes with the vector jump and return-address save
  assert_trap_vector_R10: assert property (@(posedge clk) disable iff (!rstN)
    causeLoad |-> (pcLoad && retAddrLoad && pcSel == 2'b11));
  // R8: conditional PC write never overlaps an unconditional one
  assert_cond_pc_R8: assert property (@(posedge clk) disable iff (!rstN)
    pcLoadIfEq |-> !pcLoad);
  // R11: a register write is never paired with a trap
  assert_no_wr_in_trap_R11: assert property (@(posedge clk) disable iff (!rstN)
    causeLoad |-> !rfWrite);
endmodule

// File: tb/tb_mcCtrlFsm.sv
module tb_mcCtrlFsm;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [5:0] opcode = 6'b0;
  logic aluOvf = 1'b0;
  logic addrFromAlu, memRd, memWr, instrLatch, wbFromMem, pcLoad, pcLoadIfEq;
  logic [1:0] pcSel, aluMode, aluBSel;
  logic aluASel, rfWrite, rfDstSel, causeLoad, causeCode, retAddrLoad;
  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  mcCtrlFsm dut (
    .clk(clk), .rstN(rstN), .opcode(opcode), .aluOvf(aluOvf),
    .addrFromAlu(addrFromAlu), .memRd(memRd), .memWr(memWr), .instrLatch(instrLatch),
    .wbFromMem(wbFromMem), .pcLoad(pcLoad), .pcLoadIfEq(pcLoadIfEq), .pcSel(pcSel),
    .aluMode(aluMode), .aluASel(aluASel), .aluBSel(aluBSel), .rfWrite(rfWrite),
    .rfDstSel(rfDstSel), .causeLoad(causeLoad), .causeCode(causeCode),
    .retAddrLoad(retAddrLoad)
  );

  // step codes used by the bench
  localparam logic [3:0] F = 0, D = 1, A = 2, RD = 3, WB = 4, WR = 5,
                         X = 6, RC = 7, B = 8, J = 9, TI = 10, TO = 11;

  // {opcode, ovf, length, s0, s1, s2, s3, s4}
  localparam logic [29:0] VEC [12] = '{
    {6'b100011, 1'b0, 3'd5, F, D, A, RD, WB},
    {6'b101011, 1'b0, 3'd4, F, D, A, WR, F},
    {6'b000000, 1'b0, 3'd4, F, D, X, RC, F},
    {6'b000100, 1'b0, 3'd3, F, D, B, F, F},
    {6'b000010, 1'b0, 3'd3, F, D, J, F, F},
    {6'b000000, 1'b1, 3'd4, F, D, X, TO, F},
    {6'b111111, 1'b0, 3'd3, F, D, TI, F, F},
    {6'b100011, 1'b1, 3'd5, F, D, A, RD, WB},
    {6'b000011, 1'b0, 3'd3, F, D, TI, F, F},
    {6'b101011, 1'b1, 3'd4, F, D, A, WR, F},
    {6'b000010, 1'b1, 3'd3, F, D, J, F, F},
    {6'b000000, 1'b0, 3'd4, F, D, X, RC, F}
  };

  function automatic logic [19:0] pattern(input logic [3:0] s);
    logic afa, mr, mw, il, wbm, pl, ple, aas, rw, rds, cl, cc, ral;
    logic [1:0] ps, am, abs;
    {afa, mr, mw, il, wbm, pl, ple, aas, rw, rds, cl, cc, ral} = '0;
    ps = 2'b00; am = 2'b00; abs = 2'b00;
    case (s)
      F:  begin mr = 1; il = 1; abs = 2'b01; pl = 1; end          // R2
      D:  abs = 2'b11;                                            // R3
      A:  begin aas = 1; abs = 2'b10; end                         // R4
      RD: begin mr = 1; afa = 1; end                              // R5
      WB: begin rw = 1; wbm = 1; end                              // R5
      WR: begin mw = 1; afa = 1; end                              // R6
      X:  begin aas = 1; am = 2'b10; end                          // R7
      RC: begin rw = 1; rds = 1; end                              // R7
      B:  begin aas = 1; am = 2'b01; ple = 1; ps = 2'b01; end     // R8
      J:  begin pl = 1; ps = 2'b10; end                           // R9
      TI, TO: begin cl = 1; ral = 1; pl = 1; abs = 2'b01; am = 2'b01;
                    ps = 2'b11; cc = (s == TO); end               // R10 R11
      default: ;
    endcase
    return {afa, mr, mw, il, wbm, pl, ple, ps, am, aas, abs, rw, rds, cl, cc, ral};
  endfunction

  function automatic string reqOf(input logic [3:0] s);
    case (s)
      F: return "R2"; D: return "R3"; A: return "R4";
      RD, WB: return "R5"; WR: return "R6"; X, RC: return "R7";
      B: return "R8"; J: return "R9"; TI: return "R10";
      default: return "R11";
    endcase
  endfunction

  function automatic logic [19:0] observed();
    return {addrFromAlu, memRd, memWr, instrLatch, wbFromMem, pcLoad, pcLoadIfEq,
            pcSel, aluMode, aluASel, aluBSel, rfWrite, rfDstSel, causeLoad,
            causeCode, retAddrLoad};
  endfunction

  task automatic check(input string req, input logic [19:0] exp);
    total++;
    if (observed() !== exp) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b", req, observed(), exp);
    end
  endtask

  initial begin
    #1000000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1 check("R1", pattern(F));            // R1: reset state
    @(negedge clk);
    rstN = 1'b1;
    for (int e = 0; e < 12; e++) begin
      opcode = VEC[e][29:24];
      aluOvf = VEC[e][23];
      for (int k = 0; k < int'(VEC[e][22:20]); k++) begin
        logic [3:0] st;
        st = VEC[e][19 - 4*k -: 4];
        #1 check(reqOf(st), pattern(st));   // R5 R6 R7 R8 R9 R10 R11 R12
        @(negedge clk);
      end
    end
    #1 check("R1", pattern(F));             // returned to fetch after the last entry
    // R1: asynchronous reset mid-instruction
    opcode = 6'b000100; aluOvf = 1'b0;
    @(negedge clk);
    #1 check("R3", pattern(D));
    rstN = 1'b0;
    #1 check("R1", pattern(F));
    @(negedge clk);
    rstN = 1'b1;
    #1 check("R1", pattern(F));
    @(negedge clk);
    #1 check("R3", pattern(D));
    @(negedge clk);
    #1 check("R8", pattern(B));
    // R11: overflow high in fetch and decode has no effect on a jump
    opcode = 6'b000010; aluOvf = 1'b1;
    @(negedge clk);
    #1 check("R11", pattern(F));
    @(negedge clk);
    #1 check("R11", pattern(D));
    @(negedge clk);
    #1 check("R9", pattern(J));
    @(negedge clk);
    #1 check("R9", pattern(F));
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule